// File: doc/BRIEF.md
# Function Power-State and Wake Register Block

This block stores the power management registers of a configuration-space function on a network device. Host software reaches it through a small 32-bit register port with byte enables, a byte offset, a write strobe and a read strobe. One word is a read-only capability word. It advertises in which power states the function can raise a wake request. The other word is a control/status word. It holds the requested device power state, a wake-request enable and a sticky wake-request status flag that software clears by writing a one to it.

An internal wake-event input sets the status flag, but only while the function sits in the deepest power state. The block drives a wake-request output while both the flag and the enable are set. It also presents the effective power state to the downstream clock and power logic. The two intermediate power-state encodings can be stored and read back, but they are reported downstream as fully on, because the function has no real intermediate low-power mode.

Top module: `pwr_state_regs`

## Requirements
- R1: After reset the stored power state is D0 (00), the enable and status flags are 0, `pme_req` is 0, `pwr_state_out` is 00 and `cfg_rdata` is 0.
- R2: The control/status word is at offset 0x04. Its bits [1:0] hold the power state, with D0=00, D1=01, D2=10 and D3=11. A write with `cfg_be[0]` set stores any of the four codes, and a read of offset 0x04 returns the stored code in those bits.
- R3: `pwr_state_out` is 11 when the stored state is D3 and 00 for the other three codes. It changes in the cycle after the write.
- R4: Bit 8 of the control/status word is the wake-request enable. A write with `cfg_be[1]` set stores bit 8, and the bit reads back at bit 8.
- R5: A `wake_evt` pulse sets the status flag at bit 15 in the next cycle when the stored state is D3. In any other state the pulse has no effect.
- R6: A write with `cfg_be[1]` set and `cfg_wdata[15]`=1 clears the status flag. Writing 0 there leaves it unchanged. If a wake event in D3 arrives in the same cycle as the clear, the flag stays set.
- R7: `pme_req` is 1 exactly while both the status flag and the enable flag are set. It falls in the cycle after either flag is cleared.
- R8: The capability word is at offset 0x00 and always reads 0xC003_0000. Its bits [31:27] form the wake-support mask, one bit per state: bit 31 D3cold, bit 30 D3hot, bit 29 D2, bit 28 D1 and bit 27 D0. Only the D3cold and D3hot bits are set. Writes to this word have no effect.
- R9: `cfg_rdata` updates on the clock edge that samples `cfg_rd`, so it is valid one cycle after the strobe. Offsets other than 0x00 and 0x04 read as 0. Without a read strobe, `cfg_rdata` holds its value.
- R10: A byte lane whose enable is 0 leaves the fields in that lane unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 8 | Byte offset of the register access |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_wr | input | 1 | Write strobe, one cycle per access |
| cfg_rd | input | 1 | Read strobe, one cycle per access |
| cfg_rdata | output | 32 | Registered read data |
| wake_evt | input | 1 | Internal wake event |
| pme_req | output | 1 | Wake request output |
| pwr_state_out | output | 2 | Effective power state for the clock and power logic |

## Verification
Every stored field changes on the clock edge that samples the write or wake strobe. `pme_req` and `pwr_state_out` follow those registers through logic only, so they are due one edge after the stimulus. Read data needs its own register and is due one edge after the read strobe. The bench drives every strobe for exactly one cycle on a falling edge and samples on the following falling edge. Each result is therefore compared half a period after the edge that was due to produce it, and never at an edge. Checks that a field did not change, or that `cfg_rdata` held its value, look at the output again after at least one more edge has gone by.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pstate_t;

  localparam int DATA_W   = 32;
  localparam int BE_W     = DATA_W / 8;
  localparam int EN_BIT   = 8;
  localparam int STS_BIT  = 15;
  // Wake-support mask D3cold,D3hot,D2,D1,D0 at [31:27]; version 3 at [18:16]
  localparam logic [4:0]        PME_MASK  = 5'b11000;
  localparam logic [2:0]        CAP_VER   = 3'd3;
  localparam logic [DATA_W-1:0] CAP_VALUE = {PME_MASK, 8'h00, CAP_VER, 16'h0000};
endpackage

// File: rtl/pwr_csr_core.sv
module pwr_csr_core
  import pwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_csr,
  input  logic [BE_W-1:0]   be,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wake_evt,
  output pstate_t           state_q,
  output logic              en_q,
  output logic              sts_q
);
  pstate_t state_d;
  logic    en_d;
  logic    sts_d;
  logic    ld_lane0;
  logic    ld_lane1;
  logic    wake_hit;

  assign ld_lane0 = wr_csr && be[0];
  assign ld_lane1 = wr_csr && be[1];
  assign wake_hit = wake_evt && (state_q == PS_D3);

  always_comb begin
    state_d = state_q;
    en_d    = en_q;
    sts_d   = sts_q;
    if (ld_lane0) state_d = pstate_t'(wdata[1:0]);
    if (ld_lane1) begin
      en_d = wdata[EN_BIT];
      if (wdata[STS_BIT]) sts_d = 1'b0;
    end
    if (wake_hit) sts_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_D0;
      en_q    <= 1'b0;
      sts_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      en_q    <= en_d;
      sts_q   <= sts_d;
    end
  end

  assert_sts_set_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q) |-> $past(wake_evt && state_q == PS_D3));

  assert_sts_clear_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_q) |-> $past(wr_csr && be[1] && wdata[STS_BIT]));

  assert_en_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_csr && be[1]) |=> $stable(en_q));

  assert_state_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_csr && be[0]) |=> $stable(state_q));
endmodule

// File: rtl/pwr_rd_mux.sv
module pwr_rd_mux
  import pwr_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] CAP_OFS = 'h00,
  parameter logic [ADDR_W-1:0] CSR_OFS = 'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] csr_word,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] sel;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    sel = '0;
    if (addr == CAP_OFS)      sel = CAP_VALUE;
    else if (addr == CSR_OFS) sel = csr_word;
  end

  always_comb begin
    rdata_d = rdata;
    if (rd) rdata_d = sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end

  assert_cap_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == CAP_OFS) |=> (rdata == CAP_VALUE));

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
endmodule

// File: rtl/pwr_state_regs.sv
module pwr_state_regs
  import pwr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  output logic [31:0]       cfg_rdata,
  input  logic              wake_evt,
  output logic              pme_req,
  output logic [1:0]        pwr_state_out
);
  localparam logic [ADDR_W-1:0] CAP_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CSR_OFS = ADDR_W'(4);

  pstate_t           state_q;
  logic              en_q;
  logic              sts_q;
  logic              wr_csr;
  logic [DATA_W-1:0] csr_word;

  assign wr_csr = cfg_wr && (cfg_addr == CSR_OFS);

  pwr_csr_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_csr   (wr_csr),
    .be       (cfg_be),
    .wdata    (cfg_wdata),
    .wake_evt (wake_evt),
    .state_q  (state_q),
    .en_q     (en_q),
    .sts_q    (sts_q)
  );

  always_comb begin
    csr_word          = '0;
    csr_word[1:0]     = state_q;
    csr_word[EN_BIT]  = en_q;
    csr_word[STS_BIT] = sts_q;
  end

  pwr_rd_mux #(
    .ADDR_W  (ADDR_W),
    .CAP_OFS (CAP_OFS),
    .CSR_OFS (CSR_OFS)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd       (cfg_rd),
    .addr     (cfg_addr),
    .csr_word (csr_word),
    .rdata    (cfg_rdata)
  );

  assign pme_req       = sts_q && en_q;
  assign pwr_state_out = (state_q == PS_D3) ? 2'b11 : 2'b00;

  assert_no_mid_state_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state_out != 2'b01 && pwr_state_out != 2'b10);

  assert_pme_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pme_req) |-> $past(wake_evt || (wr_csr && cfg_be[1])));

  assert_deep_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_csr && cfg_be[0] && cfg_wdata[1:0] == 2'b11) |=> (pwr_state_out == 2'b11));
endmodule

// File: tb/pwr_state_regs_test.sv
module pwr_state_regs_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_wr;
  logic        cfg_rd;
  logic [31:0] cfg_rdata;
  logic        wake_evt;
  logic        pme_req;
  logic [1:0]  pwr_state_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] CAP_EXP = 32'hC003_0000;

  always #10 clk = ~clk;

  pwr_state_regs uut (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_rdata(cfg_rdata), .wake_evt(wake_evt), .pme_req(pme_req),
    .pwr_state_out(pwr_state_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; wake_evt = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_rd = 1'b1;
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic pulse_wake();
    @(negedge clk);
    wake_evt = 1'b1;
    @(negedge clk);
    wake_evt = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 pme_req", {31'b0, pme_req}, 32'h0);
    check("R1 pwr_state_out", {30'b0, pwr_state_out}, 32'h0);
    check("R1 rdata", cfg_rdata, 32'h0);
    do_read(8'h04, d);
    check("R1 csr word", d, 32'h0);
  endtask

  task automatic t_cap();
    logic [31:0] d;
    do_read(8'h00, d);
    check("R8 cap value", d, CAP_EXP);
    check("R8 mask D3cold/D3hot only", {27'b0, d[31:27]}, 32'h18);
    do_write(8'h00, 4'hF, 32'h0000_0000);
    do_read(8'h00, d);
    check("R8 cap after write", d, CAP_EXP);
  endtask

  task automatic t_states();
    logic [31:0] d;
    for (int s = 0; s < 4; s++) begin
      do_write(8'h04, 4'h1, 32'(s));
      check("R3 pwr_state_out", {30'b0, pwr_state_out}, (s == 3) ? 32'h3 : 32'h0);
      do_read(8'h04, d);
      check("R2 state readback", {30'b0, d[1:0]}, 32'(s));
    end
    do_write(8'h04, 4'h1, 32'h0);
  endtask

  task automatic t_enable_lanes();
    logic [31:0] d;
    do_write(8'h04, 4'h2, 32'h0000_0103);
    do_read(8'h04, d);
    check("R4 enable set", {31'b0, d[8]}, 32'h1);
    check("R10 state lane masked", {30'b0, d[1:0]}, 32'h0);
    do_write(8'h04, 4'h1, 32'h0000_0003);
    do_read(8'h04, d);
    check("R10 enable lane masked", {31'b0, d[8]}, 32'h1);
    check("R10 state written", {30'b0, d[1:0]}, 32'h3);
    do_write(8'h04, 4'h2, 32'h0000_0000);
    do_read(8'h04, d);
    check("R4 enable clear", {31'b0, d[8]}, 32'h0);
  endtask

  task automatic t_wake_not_d3();
    logic [31:0] d;
    do_write(8'h04, 4'h3, 32'h0000_0102);
    pulse_wake();
    check("R5 no wake in D2 pme_req", {31'b0, pme_req}, 32'h0);
    do_read(8'h04, d);
    check("R5 no status in D2", {31'b0, d[15]}, 32'h0);
  endtask

  task automatic t_wake_d3();
    logic [31:0] d;
    do_write(8'h04, 4'h3, 32'h0000_0003);
    pulse_wake();
    check("R7 pme_req low without enable", {31'b0, pme_req}, 32'h0);
    do_read(8'h04, d);
    check("R5 status set in D3", {31'b0, d[15]}, 32'h1);
    do_write(8'h04, 4'h2, 32'h0000_0100);
    check("R7 pme_req with enable", {31'b0, pme_req}, 32'h1);
    do_write(8'h04, 4'h2, 32'h0000_0100);
    check("R6 write zero keeps status", {31'b0, pme_req}, 32'h1);
    do_write(8'h04, 4'h2, 32'h0000_0000);
    check("R7 pme_req drops with enable", {31'b0, pme_req}, 32'h0);
    do_write(8'h04, 4'h2, 32'h0000_0100);
    check("R7 pme_req back", {31'b0, pme_req}, 32'h1);
    do_write(8'h04, 4'h2, 32'h0000_8100);
    check("R6 W1C clears pme_req", {31'b0, pme_req}, 32'h0);
    do_read(8'h04, d);
    check("R6 status cleared", {31'b0, d[15]}, 32'h0);
  endtask

  task automatic t_wake_vs_clear();
    @(negedge clk);
    cfg_addr = 8'h04; cfg_be = 4'h2; cfg_wdata = 32'h0000_8100; cfg_wr = 1'b1; wake_evt = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; wake_evt = 1'b0;
    check("R6 wake beats clear", {31'b0, pme_req}, 32'h1);
    do_write(8'h04, 4'h3, 32'h0000_8000);
    check("R6 cleared and D0", {30'b0, pwr_state_out, 1'b0} | {31'b0, pme_req}, 32'h0);
  endtask

  task automatic t_read_path();
    logic [31:0] d;
    do_read(8'h00, d);
    check("R9 cap one cycle after strobe", d, CAP_EXP);
    do_write(8'h04, 4'h1, 32'h0000_0001);
    repeat (3) @(negedge clk);
    check("R9 rdata held", cfg_rdata, CAP_EXP);
    do_read(8'h08, d);
    check("R9 unmapped offset", d, 32'h0);
    do_read(8'h04, d);
    check("R2 D1 stored", d, 32'h0000_0001);
    check("R3 D1 reported as D0", {30'b0, pwr_state_out}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_addr = '0; cfg_be = '0; cfg_wdata = '0;
    cfg_wr = 1'b0; cfg_rd = 1'b0; wake_evt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cap();
    t_states();
    t_enable_lanes();
    t_wake_not_d3();
    t_wake_d3();
    t_wake_vs_clear();
    t_read_path();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule